// File: doc/BRIEF.md
# Floating-Point Sign Injection and Masked Merge Element Unit

This unit handles one vector element per cycle for the floating-point operations that only move bits. It takes a magnitude source operand (`src_a`), a sign or alternate source operand (`src_b`), a mask bit, an element width given in bytes and a two-bit operation code. One registered result comes back. Three operations set the sign of the result: copy the sign of `src_b`, copy the inverted sign of `src_b`, or XOR the two signs. The fourth operation, merge, returns one whole operand, chosen by the mask bit.

The unit treats operands as raw bit patterns. It does no arithmetic, never reads a rounding mode, raises no floating-point flags and never alters a NaN. Only 32-bit and 64-bit elements are legal. Any other width gives an exception pulse in place of a result. A sequencer upstream feeds one element per cycle with `in_valid`. It collects the registered result one cycle later when `out_valid` is high.

Top module: `fpsgn_unit`

## Requirements
- R1: In the three sign operations (op 0, 1, 2), every result bit below the element's most significant bit equals the same bit of `src_a`.
- R2: With op 0 (copy), the result sign bit equals the sign bit of `src_b`.
- R3: With op 1 (flip), the result sign bit is the inverse of the sign bit of `src_b`.
- R4: With op 2 (xor), the result sign bit is the XOR of the sign bits of `src_a` and `src_b`.
- R5: With op 3 (merge), the result is the whole `src_b` element when `mask_bit` is 1 and the whole `src_a` element when it is 0.
- R6: `width_bytes` values 4 and 8 are legal. Any other value raises `out_illegal` together with `out_valid`, and `out_data` is all zeros for that element.
- R7: With `width_bytes` = 4, the element is bits 31:0 and its sign bit is bit 31. Input bits 63:32 have no effect, and `out_data[63:32]` is zero.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Back-to-back inputs give back-to-back results.
- R9: NaN operands pass through bit-exact. No payload or quiet bit is changed, and no canonical NaN is substituted.
- R10: While `rst` is high, and on the first cycle after it, `out_valid` and `out_illegal` are 0 and `out_data` is zero, even if `in_valid` is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element present on the inputs this cycle |
| op | input | 2 | 0 copy sign, 1 flip sign, 2 xor sign, 3 merge |
| width_bytes | input | 4 | Element width in bytes (4 or 8 legal) |
| mask_bit | input | 1 | Merge select: 1 picks `src_b`, 0 picks `src_a` |
| src_a | input | 64 | Magnitude source / merge-false operand |
| src_b | input | 64 | Sign source / merge-true operand |
| out_valid | output | 1 | Registered result present |
| out_illegal | output | 1 | Registered exception for an illegal element width |
| out_data | output | 64 | Registered result element, zero-extended for 32-bit |

## Verification
The assertions check several properties on every cycle. Results follow inputs with a one-cycle delay. An illegal-width result is always valid and always zero. The upper half stays zero for narrow elements. Magnitude bits come from `src_a`, and a wide merge returns the selected operand. The bench's scenarios are needed for the rest: the correct sign rule for each operation code, exact NaN patterns, high junk bits in narrow mode, every illegal width value, and inputs asserted during reset. These depend on comparing exact result values for chosen operands.

// File: rtl/fpsgn_pkg.sv
package fpsgn_pkg;

    localparam int unsigned ELEM_MAX_W = 64;
    localparam int unsigned NARROW_W   = ELEM_MAX_W / 2;
    localparam int unsigned WSEL_W     = 4;
    localparam int unsigned NUM_WIDTHS = 2;

    typedef enum logic [1:0] {
        SGN_COPY  = 2'd0,
        SGN_FLIP  = 2'd1,
        SGN_XOR   = 2'd2,
        SGN_MERGE = 2'd3
    } sgn_op_e;

    typedef enum logic [1:0] {
        EW_NONE   = 2'd0,
        EW_NARROW = 2'd1,
        EW_WIDE   = 2'd2
    } ew_e;

    typedef struct packed {
        logic                  valid;
        logic                  illegal;
        logic [ELEM_MAX_W-1:0] data;
    } sgn_res_t;

    // Choose the sign of the result from the two operand signs.
    function automatic logic pick_sign(sgn_op_e op, logic sign_a, logic sign_b);
        logic s;
        unique case (op)
            SGN_COPY: s = sign_b;
            SGN_FLIP: s = ~sign_b;
            SGN_XOR:  s = sign_a ^ sign_b;
            default:  s = sign_b;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fpsgn_wdec.sv
module fpsgn_wdec
    import fpsgn_pkg::*;
#(
    parameter int unsigned SEL_W        = WSEL_W,
    parameter int unsigned NARROW_BYTES = NARROW_W / 8,
    parameter int unsigned WIDE_BYTES   = ELEM_MAX_W / 8
) (
    input  logic [SEL_W-1:0] width_bytes,
    output ew_e              kind
);
    localparam logic [SEL_W-1:0] NB = SEL_W'(NARROW_BYTES);
    localparam logic [SEL_W-1:0] WB = SEL_W'(WIDE_BYTES);

    always_comb begin
        if (width_bytes == NB)      kind = EW_NARROW;
        else if (width_bytes == WB) kind = EW_WIDE;
        else                        kind = EW_NONE;
    end
endmodule

// File: rtl/fpsgn_lane.sv
module fpsgn_lane
    import fpsgn_pkg::*;
#(
    parameter int unsigned LW = NARROW_W
) (
    input  sgn_op_e         op,
    input  logic            mask_bit,
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    output logic [LW-1:0]   y
);
    localparam int unsigned MSB = LW - 1;

    logic sign_r;

    always_comb begin
        sign_r = pick_sign(op, a[MSB], b[MSB]);
        if (op == SGN_MERGE) y = mask_bit ? b : a;
        else                 y = {sign_r, a[MSB-1:0]};
    end
endmodule

// File: rtl/fpsgn_oreg.sv
module fpsgn_oreg
    import fpsgn_pkg::*;
#(
    parameter int unsigned DW = ELEM_MAX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          illegal,
    input  logic [DW-1:0] data,
    output logic          q_valid,
    output logic          q_illegal,
    output logic [DW-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid   <= 1'b0;
            q_illegal <= 1'b0;
            q_data    <= '0;
        end else begin
            q_valid   <= load;
            q_illegal <= load & illegal;
            if (load) q_data <= illegal ? '0 : data;
        end
    end

    // R6: an exception is always reported as a valid element
    p_illegal_valid_r6: assert property (@(posedge clk) disable iff (rst)
        q_illegal |-> q_valid);
endmodule

// File: rtl/fpsgn_unit.sv
module fpsgn_unit
    import fpsgn_pkg::*;
#(
    parameter int unsigned DW    = ELEM_MAX_W,
    parameter int unsigned SEL_W = WSEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [SEL_W-1:0] width_bytes,
    input  logic             mask_bit,
    input  logic [DW-1:0]    src_a,
    input  logic [DW-1:0]    src_b,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [DW-1:0]    out_data
);
    localparam int unsigned NW = DW / 2;
    localparam int unsigned NLANES = NUM_WIDTHS;

    sgn_op_e     op_e;
    ew_e         kind;
    logic [DW-1:0] lane_y [NLANES];
    logic [DW-1:0] sel_y;
    sgn_res_t    nxt;

    assign op_e = sgn_op_e'(op);

    fpsgn_wdec #(
        .SEL_W       (SEL_W),
        .NARROW_BYTES(NW / 8),
        .WIDE_BYTES  (DW / 8)
    ) u_wdec (
        .width_bytes(width_bytes),
        .kind       (kind)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int unsigned LW = NW * (g + 1);
        logic [LW-1:0] y_l;
        fpsgn_lane #(.LW(LW)) u_lane (
            .op      (op_e),
            .mask_bit(mask_bit),
            .a       (src_a[LW-1:0]),
            .b       (src_b[LW-1:0]),
            .y       (y_l)
        );
        if (LW < DW) begin : g_ext
            assign lane_y[g] = {{(DW-LW){1'b0}}, y_l};
        end else begin : g_full
            assign lane_y[g] = y_l;
        end
    end

    always_comb begin
        unique case (kind)
            EW_NARROW: sel_y = lane_y[0];
            EW_WIDE:   sel_y = lane_y[1];
            default:   sel_y = '0;
        endcase
        nxt.valid   = in_valid;
        nxt.illegal = (kind == EW_NONE);
        nxt.data    = sel_y;
    end

    fpsgn_oreg #(.DW(DW)) u_oreg (
        .clk      (clk),
        .rst      (rst),
        .load     (nxt.valid),
        .illegal  (nxt.illegal),
        .data     (nxt.data),
        .q_valid  (out_valid),
        .q_illegal(out_illegal),
        .q_data   (out_data)
    );

    // R8: one-cycle latency, result only after an accepted element
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R6: illegal width yields an all-zero result
    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_data == '0));
    // R7: narrow results leave the upper half zero
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width_bytes == SEL_W'(NW / 8)) |=> (out_data[DW-1:NW] == '0));
    // R1: magnitude of a wide sign operation comes from src_a
    p_mag_wide_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width_bytes == SEL_W'(DW / 8) && op != 2'd3)
        |=> (out_data[DW-2:0] == $past(src_a[DW-2:0])));
    // R5: wide merge returns the operand picked by the mask
    p_merge_wide_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width_bytes == SEL_W'(DW / 8) && op == 2'd3)
        |=> (out_data == ($past(mask_bit) ? $past(src_b) : $past(src_a))));
endmodule

// File: tb/fpsgn_unit_tb.sv
module fpsgn_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [3:0]  width_bytes = 4'd8;
    logic        mask_bit = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic        out_illegal;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        bit          v;
        bit          ill;
        logic [63:0] d;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;  // 125 MHz

    fpsgn_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .width_bytes(width_bytes), .mask_bit(mask_bit),
        .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
    );

    function automatic exp_t model(bit v, logic [1:0] o, logic [3:0] w, bit m,
                                   logic [63:0] a, logic [63:0] b, string tag);
        exp_t e;
        int msb;
        logic s;
        logic [63:0] r;
        e.v = v; e.tag = tag; e.ill = 0; e.d = '0;
        if (!v) return e;
        if (w != 4'd4 && w != 4'd8) begin
            e.ill = 1; return e;
        end
        msb = (w == 4'd4) ? 31 : 63;
        if (o == 2'd3) begin
            r = m ? b : a;
        end else begin
            case (o)
                2'd0: s = b[msb];
                2'd1: s = !b[msb];
                default: s = a[msb] ^ b[msb];
            endcase
            r = a;
            r[msb] = s;
        end
        if (w == 4'd4) r[63:32] = '0;
        e.d = r;
        return e;
    endfunction

    task automatic drive(bit v, logic [1:0] o, logic [3:0] w, bit m,
                         logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        in_valid = v; op = o; width_bytes = w; mask_bit = m; src_a = a; src_b = b;
        q.push_back(model(v, o, w, m, a, b, tag));
    endtask

    // monitor: sample 2 ns after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (mon_en && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v || out_illegal !== e.ill ||
                (e.v && out_data !== e.d)) begin
                errors++;
                $display("FAIL %s: got v=%0b ill=%0b d=%h expected v=%0b ill=%0b d=%h",
                         e.tag, out_valid, out_illegal, out_data, e.v, e.ill, e.d);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: inputs active during reset must not leak out
        in_valid = 1'b1; src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'h1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (out_valid !== 0 || out_illegal !== 0 || out_data !== '0) begin
            errors++;
            $display("FAIL R10: got v=%0b ill=%0b d=%h expected 0 0 0",
                     out_valid, out_illegal, out_data);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        @(posedge clk); #2;
        checks++;
        if (out_valid !== 0 || out_illegal !== 0 || out_data !== '0) begin
            errors++;
            $display("FAIL R10: got v=%0b ill=%0b d=%h after release expected 0 0 0",
                     out_valid, out_illegal, out_data);
        end
        mon_en = 1'b1;

        // R2/R3/R4 on 64-bit, all sign combinations (R1 magnitude kept)
        for (int sa = 0; sa < 2; sa++)
            for (int sb = 0; sb < 2; sb++) begin
                logic [63:0] a = {sa[0], 63'h0123_4567_89AB_CDEF};
                logic [63:0] b = {sb[0], 63'h7654_3210_FEDC_BA98};
                drive(1, 2'd0, 4'd8, 0, a, b, "R2");
                drive(1, 2'd1, 4'd8, 0, a, b, "R3");
                drive(1, 2'd2, 4'd8, 1, a, b, "R4");
            end
        // R7: 32-bit with junk in the upper input halves
        drive(1, 2'd0, 4'd4, 0, 64'hDEAD_BEEF_3F80_0000, 64'h5555_5555_8000_0000, "R7");
        drive(1, 2'd1, 4'd4, 0, 64'hAAAA_AAAA_BF80_0000, 64'hFFFF_FFFF_0000_0000, "R7");
        drive(1, 2'd2, 4'd4, 0, 64'h1234_5678_C000_0001, 64'h8000_0000_8000_0000, "R7");
        drive(1, 2'd3, 4'd4, 1, 64'hFFFF_FFFF_1111_1111, 64'hEEEE_EEEE_2222_2222, "R7");
        // R5: merge in both widths, both mask values
        drive(1, 2'd3, 4'd8, 0, 64'hC0DE_0000_0000_0001, 64'h8BAD_F00D_0000_0002, "R5");
        drive(1, 2'd3, 4'd8, 1, 64'hC0DE_0000_0000_0001, 64'h8BAD_F00D_0000_0002, "R5");
        drive(1, 2'd3, 4'd4, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        // R9: NaN payloads untouched
        drive(1, 2'd1, 4'd8, 0, 64'h7FF4_0000_0000_0001, 64'h0, "R9");
        drive(1, 2'd0, 4'd4, 0, 64'h0000_0000_7FA0_0001, 64'h0000_0000_8000_0000, "R9");
        drive(1, 2'd3, 4'd8, 1, 64'h0, 64'hFFF8_DEAD_BEEF_0001, "R9");
        // R6: every illegal width value
        for (int w = 0; w < 16; w++)
            if (w != 4 && w != 8)
                drive(1, 2'(w), 4'(w), w[0], 64'hFFFF_FFFF_FFFF_FFFF,
                      64'h8000_0000_0000_0000, "R6");
        // R8: gaps and back-to-back
        drive(0, 2'd0, 4'd8, 0, 64'h1, 64'h1, "R8");
        drive(1, 2'd0, 4'd8, 0, 64'h1, 64'h8000_0000_0000_0000, "R8");
        drive(0, 2'd1, 4'd4, 0, 64'h2, 64'h2, "R8");
        drive(0, 2'd1, 4'd4, 0, 64'h2, 64'h2, "R8");
        drive(1, 2'd1, 4'd4, 0, 64'h3, 64'h0, "R8");
        // random mix (R1 magnitude and all rules)
        for (int i = 0; i < 300; i++) begin
            logic [3:0] w;
            logic [63:0] a, b;
            logic [1:0] o;
            w = ($urandom % 8 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd8 : 4'd4);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            o = 2'($urandom);
            drive(($urandom % 5) != 0, o, w, 1'($urandom), a, b, "R1");
        end
        drive(0, 2'd0, 4'd8, 0, 64'h0, 64'h0, "R8");
        drive(0, 2'd0, 4'd8, 0, 64'h0, 64'h0, "R8");
        @(posedge clk); #3;
        mon_en = 1'b0;
        done = 1'b1;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R8: got %0d pending results expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule